// File: doc/BRIEF.md
# Word-Serial Multiprecision Multiplier

This block multiplies two unsigned integers of `NWORDS` 32-bit words each. Each operand is a little-endian array of words, so the value is the sum of word k times 2^(32k). The result is the full product of `2*NWORDS` words. `NWORDS` is a synthesis parameter; the supported range is 2 to 16, which covers operands of 64 to 512 bits.

A `start` pulse begins a run. The block first reads every multiplicand word through its X read port into local registers. It then runs one step per multiplier word, reading that word through the Y read port. In each step it adds the multiplicand times that word into an accumulator window of `NWORDS+1` words. The multiplicand is handled as two interleaved halves: the even-indexed words go first, then the odd-indexed words, so the products inside each half never overlap.

The bottom word of the window is final at the end of each step. It is written out through the result port, and the window then slides down by one word. After the last step, a drain pass writes the remaining upper words. A single two-stage pipelined 32x32 multiplier forms every partial product. Both read ports are combinational: the data must be valid in the same cycle as the address.

Top module: `wsmul`

## Requirements
- R1: While reset is held, `busy`, `done` and `r_we` are all 0.
- R2: Over one run, the words written form the exact unsigned product of X and Y: word k of the product appears on `r_data` when `r_idx` equals k.
- R3: Each run writes `2*NWORDS` words. Their indices rise by one from 0 to `2*NWORDS-1`, and each index is written exactly once.
- R4: Write timing is fixed. Let offset 0 be the cycle in which `start` is accepted. Word i (for i below `NWORDS`) is written at offset 2N+3+i(N+3), where N is `NWORDS`. Upper word N+k is written at offset N²+4N+1+k. No write happens at any other offset.
- R5: `busy` is high from offset 1 through offset N²+5N+1. `done` is high only at that last offset, for exactly one cycle, and it follows the final write directly. In the next cycle `busy` is 0.
- R6: `start` has no effect while `busy` is high, including the cycle in which `done` is high. Holding `start` high for a whole run changes neither the timing nor the result.
- R7: The X port is read only during offsets 1 to N. Changes on `x_rd_data` after that do not alter the result.
- R8: Within each step, the addition that reaches the top word of the window never carries out of it. This holds even when both operands are all ones, and the product is still exact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; sampled only while idle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after the last result word |
| x_rd_addr | output | $clog2(NWORDS) | Multiplicand word index |
| x_rd_data | input | 32 | Multiplicand word at `x_rd_addr` (same cycle) |
| y_rd_addr | output | $clog2(NWORDS) | Multiplier word index |
| y_rd_data | input | 32 | Multiplier word at `y_rd_addr` (same cycle) |
| r_we | output | 1 | Result word write strobe |
| r_idx | output | $clog2(2*NWORDS) | Result word index |
| r_data | output | 32 | Result word |

## Verification
The bench drives all-ones operands into both ports. This stresses every carry. A design that flushed the carry at the end of a half-pass into the wrong word, or that lost it, would return a wrong upper word. A design that let the top word of the window overflow would corrupt the next step.

A zero multiplier and a multiplier of one check that the window is cleared between runs and slides correctly. A stale window would leak words from the previous run.

One run holds `start` high throughout, including the cycle in which `done` is high. A block that restarted would shift every later write and raise `busy` again.

Another run changes the X memory once the load phase is over. A design that read the multiplicand again during its steps would write words that differ from the product of the original operands.

// File: rtl/wsmul_pkg.sv
package wsmul_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0]   word_t;
  typedef logic [2*WORD_W-1:0] dword_t;
  typedef enum logic [2:0] {
    S_IDLE, S_LDX, S_MUL, S_WAIT, S_SHIFT, S_DRAIN, S_DONE
  } st_e;
endpackage

// File: rtl/wsmul_mulpipe.sv
module wsmul_mulpipe
  import wsmul_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_v,
  input  word_t            in_a,
  input  word_t            in_b,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_v,
  output dword_t           out_p,
  output logic [TAG_W-1:0] out_tag
);
  logic             v1_q, v2_q;
  dword_t           p1_q, p2_q;
  logic [TAG_W-1:0] t1_q, t2_q;

  // valid bits carry the reset; data stages only load when enabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= in_v;
      v2_q <= v1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (in_v) begin
      p1_q <= dword_t'(in_a) * dword_t'(in_b);
      t1_q <= in_tag;
    end
    if (v1_q) begin
      p2_q <= p1_q;
      t2_q <= t1_q;
    end
  end

  assign out_v   = v2_q;
  assign out_p   = p2_q;
  assign out_tag = t2_q;

  // R2: product arrives two cycles after issue and matches the operands
  p_mul_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_v |=> ##1 out_v);
  p_mul_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_v |-> out_p == dword_t'($past(in_a, 2)) * dword_t'($past(in_b, 2)));
endmodule

// File: rtl/wsmul_window.sv
module wsmul_window
  import wsmul_pkg::*;
#(
  parameter int NWORDS = 4,
  parameter int AW     = $clog2(NWORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          add_en,
  input  logic [AW-1:0] add_off,
  input  dword_t        add_p,
  input  logic          add_first,
  input  logic          add_last,
  input  logic          shift_en,
  output word_t         low_word
);
  localparam int TOP = NWORDS;

  word_t         win_q [0:TOP];
  word_t         win_d [0:TOP];
  logic          carry_q, carry_d;
  logic [2*WORD_W:0] sum;
  int            off;

  always_comb begin
    off = int'(add_off);
    sum = {1'b0, win_q[off+1], win_q[off]} + {1'b0, add_p}
        + (2*WORD_W+1)'(add_first ? 1'b0 : carry_q);
    for (int k = 0; k <= TOP; k++) win_d[k] = win_q[k];
    carry_d = carry_q;
    if (clr) begin
      for (int k = 0; k <= TOP; k++) win_d[k] = '0;
      carry_d = 1'b0;
    end else if (add_en) begin
      win_d[off]   = sum[WORD_W-1:0];
      win_d[off+1] = sum[2*WORD_W-1:WORD_W];
      carry_d      = sum[2*WORD_W];
      // a half-pass ending below the top word hands its carry to the top word
      if (add_last && (off + 2 <= TOP))
        win_d[off+2] = win_q[off+2] + word_t'(sum[2*WORD_W]);
    end else if (shift_en) begin
      for (int k = 0; k < TOP; k++) win_d[k] = win_q[k+1];
      win_d[TOP] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k <= TOP; k++) win_q[k] <= '0;
      carry_q <= 1'b0;
    end else begin
      for (int k = 0; k <= TOP; k++) win_q[k] <= win_d[k];
      carry_q <= carry_d;
    end
  end

  assign low_word = win_q[0];

  // R8: the pair reaching the top word never carries out
  p_top_no_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (add_en && !clr && (int'(add_off) == TOP - 1)) |-> !sum[2*WORD_W]);
  // R3: a slide always clears the top word
  p_shift_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !add_en && !clr) |=> win_q[TOP] == '0);
endmodule

// File: rtl/wsmul.sv
module wsmul
  import wsmul_pkg::*;
#(
  parameter int NWORDS = 4,
  parameter int AW     = $clog2(NWORDS),
  parameter int IW     = $clog2(2*NWORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] x_rd_addr,
  input  logic [31:0]   x_rd_data,
  output logic [AW-1:0] y_rd_addr,
  input  logic [31:0]   y_rd_data,
  output logic          r_we,
  output logic [IW-1:0] r_idx,
  output logic [31:0]   r_data
);
  localparam int             HALF     = (NWORDS + 1) / 2;
  localparam int             TAG_W    = AW + 3;
  localparam logic [AW-1:0]  CNT_LAST = AW'(NWORDS - 1);
  localparam logic [AW-1:0]  CNT_HALF = AW'(HALF);

  st_e           st_q, st_d;
  logic [AW-1:0] cnt_q, cnt_d, step_q, step_d;
  word_t         xr [0:NWORDS-1];
  logic          x_we, iss_v, win_clr, shift_en;
  logic [AW-1:0] iss_j;
  logic          iss_first, iss_last, iss_fin;
  logic          mp_v;
  dword_t        mp_p;
  logic [TAG_W-1:0] mp_tag;
  word_t         low_word;

  // issue order: even words first, then odd words
  always_comb begin
    if (cnt_q < CNT_HALF) iss_j = AW'({cnt_q, 1'b0});
    else                  iss_j = AW'({cnt_q - CNT_HALF, 1'b1});
    iss_first = (cnt_q == '0) || (cnt_q == CNT_HALF);
    iss_last  = (cnt_q == CNT_HALF - 1'b1) || (cnt_q == CNT_LAST);
    iss_fin   = (cnt_q == CNT_LAST);
  end

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    step_d   = step_q;
    x_we     = 1'b0;
    iss_v    = 1'b0;
    win_clr  = 1'b0;
    shift_en = 1'b0;
    unique case (st_q)
      S_IDLE: if (start) begin
        st_d    = S_LDX;
        cnt_d   = '0;
        win_clr = 1'b1;
      end
      S_LDX: begin
        x_we = 1'b1;
        if (cnt_q == CNT_LAST) begin
          st_d   = S_MUL;
          cnt_d  = '0;
          step_d = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      S_MUL: begin
        iss_v = 1'b1;
        if (cnt_q == CNT_LAST) begin
          st_d  = S_WAIT;
          cnt_d = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      S_WAIT: if (mp_v && mp_tag[0]) st_d = S_SHIFT;
      S_SHIFT: begin
        shift_en = 1'b1;
        if (step_q == CNT_LAST) begin
          st_d  = S_DRAIN;
          cnt_d = '0;
        end else begin
          st_d   = S_MUL;
          step_d = step_q + 1'b1;
        end
      end
      S_DRAIN: begin
        shift_en = 1'b1;
        if (cnt_q == CNT_LAST) st_d = S_DONE;
        else                   cnt_d = cnt_q + 1'b1;
      end
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      step_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      step_q <= step_d;
    end
  end

  always_ff @(posedge clk) begin
    if (x_we) xr[cnt_q] <= x_rd_data;
  end

  wsmul_mulpipe #(.TAG_W(TAG_W)) mul_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_v    (iss_v),
    .in_a    (xr[iss_j]),
    .in_b    (y_rd_data),
    .in_tag  ({iss_j, iss_first, iss_last, iss_fin}),
    .out_v   (mp_v),
    .out_p   (mp_p),
    .out_tag (mp_tag)
  );

  wsmul_window #(.NWORDS(NWORDS), .AW(AW)) win_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (win_clr),
    .add_en    (mp_v),
    .add_off   (mp_tag[TAG_W-1:3]),
    .add_p     (mp_p),
    .add_first (mp_tag[2]),
    .add_last  (mp_tag[1]),
    .shift_en  (shift_en),
    .low_word  (low_word)
  );

  assign x_rd_addr = cnt_q;
  assign y_rd_addr = step_q;
  assign busy      = (st_q != S_IDLE);
  assign done      = (st_q == S_DONE);
  assign r_we      = (st_q == S_SHIFT) || (st_q == S_DRAIN);
  assign r_idx     = (st_q == S_SHIFT) ? IW'(step_q) : IW'(NWORDS) + IW'(cnt_q);
  assign r_data    = low_word;

  // R5: done lasts one cycle and returns the block to idle
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_idle_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R3: back-to-back writes step the index by one
  p_write_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (r_we && $past(r_we)) |-> r_idx == $past(r_idx) + 1'b1);
  // R6: a start seen mid-run never re-enters the load phase
  p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st_q != S_IDLE && st_q != S_LDX) |=> st_q != S_LDX);
endmodule

// File: tb/wsmul_tb_top.sv
module wsmul_tb_top;
  import wsmul_pkg::*;
  localparam int NW         = 4;
  localparam int CLK_PERIOD = 10;
  localparam int AW         = $clog2(NW);
  localparam int IW         = $clog2(2*NW);
  localparam int PW         = 2*NW*32;
  localparam int D_OFS      = NW*NW + 5*NW + 1;
  localparam int DRAIN0     = NW*NW + 4*NW + 1;

  logic          clk, rst_n, start, busy, done, r_we;
  logic [AW-1:0] x_rd_addr, y_rd_addr;
  logic [31:0]   x_rd_data, y_rd_data, r_data;
  logic [IW-1:0] r_idx;

  word_t xm [NW];
  word_t ym [NW];
  assign x_rd_data = xm[x_rd_addr];
  assign y_rd_data = ym[y_rd_addr];

  wsmul #(.NWORDS(NW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .x_rd_addr(x_rd_addr), .x_rd_data(x_rd_data),
    .y_rd_addr(y_rd_addr), .y_rd_data(y_rd_data),
    .r_we(r_we), .r_idx(r_idx), .r_data(r_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  function automatic logic [PW-1:0] ref_prod();
    logic [PW-1:0] a, b;
    a = '0;
    b = '0;
    for (int k = 0; k < NW; k++) begin
      a[k*32 +: 32] = xm[k];
      b[k*32 +: 32] = ym[k];
    end
    return a * b;
  endfunction

  function automatic int exp_idx(input int o);
    for (int i = 0; i < NW; i++)
      if (o == 2*NW + 3 + i*(NW + 3)) return i;
    if (o >= DRAIN0 && o < DRAIN0 + NW) return NW + o - DRAIN0;
    return -1;
  endfunction

  // behavioural model: run flag, cycle offset, snapshot product
  bit            run = 1'b0;
  int            ofs = 0;
  int            nwr = 0;
  logic [PW-1:0] exp_p = '0;
  word_t         got [2*NW];

  always @(posedge clk) begin
    if (!rst_n) begin
      run = 1'b0;
      ofs = 0;
    end else if (run) begin
      if (ofs == D_OFS) run = 1'b0;
      else ofs++;
    end else if (start) begin
      run   = 1'b1;
      ofs   = 1;
      nwr   = 0;
      exp_p = ref_prod();
    end
  end

  always @(negedge clk) begin
    int    e;
    string tg;
    e  = run ? exp_idx(ofs) : -1;
    tg = rst_n ? "R5" : "R1";
    chk(busy == run, tg, "busy", 64'(busy), 64'(run));
    chk(done == (run && ofs == D_OFS), tg, "done", 64'(done), 64'(run && ofs == D_OFS));
    chk(r_we == (e >= 0), rst_n ? "R4" : "R1", "write strobe", 64'(r_we), 64'(e >= 0));
    if (r_we && e >= 0) begin
      chk(int'(r_idx) == e, "R3", "index", 64'(r_idx), 64'(e));
      chk(r_data == exp_p[e*32 +: 32], "R2", "word", 64'(r_data), 64'(exp_p[e*32 +: 32]));
      got[r_idx] = r_data;
      nwr++;
    end
  end

  task automatic final_cmp(input string tag);
    chk(nwr == 2*NW, "R3", "write count", 64'(nwr), 64'(2*NW));
    for (int k = 0; k < 2*NW; k++)
      chk(got[k] == exp_p[k*32 +: 32], tag, "stored word", 64'(got[k]), 64'(exp_p[k*32 +: 32]));
  endtask

  task automatic run_case(input string tag);
    for (int k = 0; k < 2*NW; k++) got[k] = '0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (run) @(negedge clk);
    final_cmp(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    for (int k = 0; k < NW; k++) begin xm[k] = '0; ym[k] = '0; end
    repeat (3) @(negedge clk);   // R1 checked by monitor while reset is low
    rst_n = 1'b1;
    @(negedge clk);

    // R2: small ascending pattern
    for (int k = 0; k < NW; k++) begin xm[k] = 32'(k + 1); ym[k] = 32'h1_0000 * 32'(k + 3); end
    run_case("R2");

    // R8: all ones in both operands
    for (int k = 0; k < NW; k++) begin xm[k] = '1; ym[k] = '1; end
    run_case("R8");

    // R2: zero multiplier after a full run clears the window
    for (int k = 0; k < NW; k++) ym[k] = '0;
    run_case("R2");

    // R2: multiplier of one returns the multiplicand
    for (int k = 0; k < NW; k++) begin xm[k] = '1; ym[k] = (k == 0) ? 32'd1 : 32'd0; end
    run_case("R2");

    // R2: random operands
    for (int n = 0; n < 4; n++) begin
      for (int k = 0; k < NW; k++) begin xm[k] = $urandom; ym[k] = $urandom; end
      run_case("R2");
    end

    // R6: start held high for the whole run including the done cycle
    for (int k = 0; k < NW; k++) begin xm[k] = $urandom; ym[k] = $urandom; got[k] = '0; got[k+NW] = '0; end
    @(negedge clk) start = 1'b1;
    @(negedge clk);
    while (!(run && ofs == D_OFS)) @(negedge clk);
    @(negedge clk) start = 1'b0;
    chk(!busy, "R6", "busy after held start", 64'(busy), 64'(0));
    final_cmp("R6");
    @(negedge clk);
    chk(!busy, "R6", "no restart", 64'(busy), 64'(0));

    // R7: multiplicand memory rewritten after the load phase
    for (int k = 0; k < NW; k++) begin xm[k] = $urandom; ym[k] = $urandom; got[k] = '0; got[k+NW] = '0; end
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (ofs < NW + 1) @(negedge clk);
    for (int k = 0; k < NW; k++) xm[k] = ~xm[k] ^ 32'h5a5a_0f0f;
    while (run) @(negedge clk);
    final_cmp("R7");

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule